// File: doc/BRIEF.md
# Calendar Alarm Matcher

This block watches a running calendar kept elsewhere on the chip and decides when a programmed alarm moment has come. It holds five alarm bytes (second, minute, hour, day of month, weekday), each with its own disable bit, so software can match any subset of the fields: "every hour at minute 15", "each Tuesday at 07:30:00", and so on. The second, minute, hour and day fields are compared as BCD bytes; the weekday is a plain 3-bit number.

On every cycle where the external seconds strobe is high, each enabled alarm field is compared with the matching calendar field. When all enabled fields agree, a sticky alarm flag is set. An active-low interrupt line, meant to drive an open-drain pad, is low while the flag and the alarm interrupt enable are both set. Software reaches the block through a simple synchronous register port. It clears the flag by writing 0 to the flag bit, typically before it loads a new alarm.

Top module: `calendar_alarm`

## Requirements
- R1: After reset `alarm_irq_n` is 1, the control register at address 0x01 reads 0x00, and all five alarm registers read 0x80, meaning every field is disabled.
- R2: The alarm registers are at 0x0A (second), 0x0B (minute), 0x0C (hour), 0x0D (day) and 0x0E (weekday). Bit 7 of each is its disable bit. The value bits kept are [6:0] for second and minute, [5:0] for hour and day, and [2:0] for weekday. Bits not kept read as 0. `reg_rdata` shows the register at `reg_addr` one clock after the address is applied.
- R3: The flag is set on the clock edge that ends a cycle in which `sec_tick` is 1 and every enabled field equals its calendar input. A match while `sec_tick` is 0 has no effect.
- R4: Once set, the flag stays set through later ticks that do not match, until software clears it.
- R5: When all five disable bits are set, the flag is never set, whatever the calendar values are.
- R6: In the control register, bit 4 is the flag and bit 1 is the interrupt enable, which is written directly. `alarm_irq_n` is registered and is 0 exactly when both bits are 1. It changes on the same edge as the flag or the enable.
- R7: Writing the control register with bit 4 = 0 clears the flag. Writing it with bit 4 = 1 leaves the flag unchanged. If a match and a clearing write happen in the same cycle, the flag ends up set.
- R8: A disabled field is left out of the comparison, so any calendar value in that field still allows a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sec_tick | input | 1 | One-cycle strobe each time the calendar seconds advance |
| cal_sec | input | 7 | Calendar seconds, BCD |
| cal_min | input | 7 | Calendar minutes, BCD |
| cal_hour | input | 6 | Calendar hours, BCD |
| cal_day | input | 6 | Calendar day of month, BCD |
| cal_wday | input | 3 | Calendar weekday, binary |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for `reg_addr` |
| alarm_irq_n | output | 1 | Alarm interrupt, active low |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, a 5-bit address, the alarm bank based at 0x0A and the control register at 0x01. With these values every alarm field, including the narrow hour, day and weekday masks, can be reached through the register port, and the bench can drive each calendar field to both equal and unequal values. This makes it possible to test subset matching with disabled fields, a full five-field match, the all-disabled case, and a match that coincides with a clearing write.

// File: rtl/calalm_pkg.sv
package calalm_pkg;
  localparam int DATA_W     = 8;
  localparam int NUM_FIELDS = 5;
  localparam int DIS_BIT    = 7;
  localparam int FLAG_BIT   = 4;
  localparam int EN_BIT     = 1;

  // value bits kept for each field (sec, min, hour, day, wday)
  function automatic logic [DATA_W-1:0] value_mask(input int idx);
    case (idx)
      0, 1:    return 8'h7F;
      2, 3:    return 8'h3F;
      4:       return 8'h07;
      default: return 8'h00;
    endcase
  endfunction

  // everything a register stores, disable bit included
  function automatic logic [DATA_W-1:0] store_mask(input int idx);
    return value_mask(idx) | (DATA_W'(1) << DIS_BIT);
  endfunction
endpackage

// File: rtl/calalm_regs.sv
module calalm_regs
  import calalm_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int ALARM_BASE = 10
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [DATA_W-1:0]                   wdata,
  output logic [NUM_FIELDS-1:0][DATA_W-1:0]   alarm_q
);
  localparam logic [DATA_W-1:0] RST_VAL = DATA_W'(1) << DIS_BIT;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(ALARM_BASE + i);
    localparam logic [DATA_W-1:0] KEEP    = store_mask(i);
    always_ff @(posedge clk) begin
      if (rst)
        alarm_q[i] <= RST_VAL;
      else if (wr && addr == MY_ADDR)
        alarm_q[i] <= wdata & KEEP;
    end
  end
endmodule

// File: rtl/calalm_match.sv
module calalm_match
  import calalm_pkg::*;
(
  input  logic                              tick,
  input  logic [NUM_FIELDS-1:0][DATA_W-1:0] alarm_q,
  input  logic [NUM_FIELDS-1:0][DATA_W-1:0] cal_vals,
  output logic                              fire,
  output logic                              all_off
);
  logic [NUM_FIELDS-1:0] hit;
  logic [NUM_FIELDS-1:0] off;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
    localparam logic [DATA_W-1:0] VM = value_mask(i);
    assign off[i] = alarm_q[i][DIS_BIT];
    assign hit[i] = off[i] | ((alarm_q[i] & VM) == (cal_vals[i] & VM));
  end

  assign all_off = &off;
  assign fire    = tick & (&hit) & ~all_off;
endmodule

// File: rtl/calalm_flag.sv
module calalm_flag
  import calalm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic ctrl_wr,
  input  logic wr_flag_bit,
  input  logic wr_en_bit,
  output logic flag_q,
  output logic en_q,
  output logic irq_n
);
  logic flag_d, en_d;

  always_comb begin
    flag_d = flag_q;
    if (ctrl_wr && !wr_flag_bit) flag_d = 1'b0;
    if (fire)                    flag_d = 1'b1;  // a hardware event beats a clear
    en_d = ctrl_wr ? wr_en_bit : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      en_q   <= 1'b0;
      irq_n  <= 1'b1;
    end else begin
      flag_q <= flag_d;
      en_q   <= en_d;
      irq_n  <= ~(flag_d & en_d);
    end
  end
endmodule

// File: rtl/calendar_alarm.sv
module calendar_alarm
  import calalm_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int ALARM_BASE = 10,
  parameter int CTRL_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic [6:0]        cal_sec,
  input  logic [6:0]        cal_min,
  input  logic [5:0]        cal_hour,
  input  logic [5:0]        cal_day,
  input  logic [2:0]        cal_wday,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              alarm_irq_n
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  logic [NUM_FIELDS-1:0][DATA_W-1:0] alarm_q;
  logic [NUM_FIELDS-1:0][DATA_W-1:0] cal_vals;
  logic fire_w, all_off_w, flag_q, en_q, ctrl_wr_w;
  logic [DATA_W-1:0] rd_mux;

  assign cal_vals[0] = DATA_W'(cal_sec);
  assign cal_vals[1] = DATA_W'(cal_min);
  assign cal_vals[2] = DATA_W'(cal_hour);
  assign cal_vals[3] = DATA_W'(cal_day);
  assign cal_vals[4] = DATA_W'(cal_wday);

  assign ctrl_wr_w = reg_wr && (reg_addr == CTRL_A);

  calalm_regs #(.ADDR_W(ADDR_W), .ALARM_BASE(ALARM_BASE)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .alarm_q(alarm_q)
  );

  calalm_match u_match (
    .tick(sec_tick), .alarm_q(alarm_q), .cal_vals(cal_vals),
    .fire(fire_w), .all_off(all_off_w)
  );

  calalm_flag u_flag (
    .clk(clk), .rst(rst), .fire(fire_w), .ctrl_wr(ctrl_wr_w),
    .wr_flag_bit(reg_wdata[FLAG_BIT]), .wr_en_bit(reg_wdata[EN_BIT]),
    .flag_q(flag_q), .en_q(en_q), .irq_n(alarm_irq_n)
  );

  always_comb begin
    rd_mux = '0;
    if (reg_addr == CTRL_A) begin
      rd_mux[FLAG_BIT] = flag_q;
      rd_mux[EN_BIT]   = en_q;
    end
    for (int i = 0; i < NUM_FIELDS; i++)
      if (reg_addr == ADDR_W'(ALARM_BASE + i)) rd_mux = alarm_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/calalm_chk.sv
module calalm_chk (
  input logic clk,
  input logic rst,
  input logic sec_tick,
  input logic ctrl_wr,
  input logic wr_flag_bit,
  input logic fire,
  input logic all_off,
  input logic flag,
  input logic en,
  input logic irq_n
);
  // R3
  fire_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> flag);
  // R3
  fire_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    fire |-> sec_tick);
  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !(ctrl_wr && !wr_flag_bit)) |=> flag);
  // R7
  no_sw_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!flag && !fire) |=> !flag);
  // R5
  all_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    all_off |-> !fire);
  // R6
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> (flag && en));
endmodule

bind calendar_alarm calalm_chk u_chk (
  .clk(clk), .rst(rst), .sec_tick(sec_tick), .ctrl_wr(ctrl_wr_w),
  .wr_flag_bit(reg_wdata[4]), .fire(fire_w), .all_off(all_off_w),
  .flag(flag_q), .en(en_q), .irq_n(alarm_irq_n)
);

// File: tb/calendar_alarm_tb.sv
module calendar_alarm_tb;
  logic clk = 0;
  logic rst = 1;
  logic sec_tick = 0;
  logic [6:0] cal_sec = 0, cal_min = 0;
  logic [5:0] cal_hour = 0, cal_day = 0;
  logic [2:0] cal_wday = 0;
  logic [4:0] reg_addr = 0;
  logic reg_wr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic alarm_irq_n;

  int n_checks = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  logic rd_req = 0, rd_pend = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  calendar_alarm u_dut (
    .clk(clk), .rst(rst), .sec_tick(sec_tick),
    .cal_sec(cal_sec), .cal_min(cal_min), .cal_hour(cal_hour),
    .cal_day(cal_day), .cal_wday(cal_wday),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .alarm_irq_n(alarm_irq_n)
  );

  function automatic void check(logic [7:0] act, logic [7:0] exp, string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endfunction

  function automatic void finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endfunction

  // monitor: pops expected read data as the design produces it
  always @(posedge clk) rd_pend <= rd_req;
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0)
      check(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_req = 1;
    @(negedge clk);
    rd_req = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic set_cal(input logic [6:0] s, input logic [6:0] m,
                         input logic [5:0] h, input logic [5:0] d, input logic [2:0] w);
    cal_sec = s; cal_min = m; cal_hour = h; cal_day = d; cal_wday = w;
  endtask

  task automatic tick_once();
    @(negedge clk);
    sec_tick = 1;
    @(negedge clk);
    sec_tick = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check({7'b0, alarm_irq_n}, 8'h01, "R1 irq_n after reset");
    rd(5'h01, 8'h00, "R1 control after reset");
    for (int i = 0; i < 5; i++) rd(5'(10 + i), 8'h80, "R1 alarm reg after reset");

    // R5 all disabled: equal-looking values never fire
    wr(5'h01, 8'h02);
    set_cal(7'h00, 7'h00, 6'h00, 6'h00, 3'h0);
    tick_once();
    check({7'b0, alarm_irq_n}, 8'h01, "R5 all disabled irq_n");
    rd(5'h01, 8'h02, "R5 all disabled flag clear");

    // R2 stored bits and layout
    for (int i = 0; i < 5; i++) wr(5'(10 + i), 8'hFF);
    rd(5'h0A, 8'hFF, "R2 second mask");
    rd(5'h0B, 8'hFF, "R2 minute mask");
    rd(5'h0C, 8'hBF, "R2 hour mask");
    rd(5'h0D, 8'hBF, "R2 day mask");
    rd(5'h0E, 8'h87, "R2 weekday mask");
    wr(5'h0A, 8'h30); wr(5'h0B, 8'h15);
    wr(5'h0C, 8'h80); wr(5'h0D, 8'h80); wr(5'h0E, 8'h80);
    rd(5'h0A, 8'h30, "R2 second readback");

    // R3 mismatching tick, then matching tick with hour disabled (R8)
    set_cal(7'h29, 7'h15, 6'h07, 6'h01, 3'h2);
    tick_once();
    check({7'b0, alarm_irq_n}, 8'h01, "R3 mismatch no fire");
    set_cal(7'h30, 7'h15, 6'h23, 6'h31, 3'h6);
    tick_once();
    check({7'b0, alarm_irq_n}, 8'h00, "R8 match with disabled fields");
    rd(5'h01, 8'h12, "R6 flag and enable set");

    // R4 sticky across non-matching tick
    set_cal(7'h31, 7'h15, 6'h23, 6'h31, 3'h6);
    tick_once();
    check({7'b0, alarm_irq_n}, 8'h00, "R4 flag sticky");

    // R7 writing 1 keeps, writing 0 clears
    wr(5'h01, 8'h12);
    check({7'b0, alarm_irq_n}, 8'h00, "R7 write one keeps flag");
    wr(5'h01, 8'h02);
    check({7'b0, alarm_irq_n}, 8'h01, "R7 write zero clears flag");
    rd(5'h01, 8'h02, "R7 control after clear");

    // R3 match without tick
    set_cal(7'h30, 7'h15, 6'h00, 6'h00, 3'h0);
    repeat (4) @(negedge clk);
    check({7'b0, alarm_irq_n}, 8'h01, "R3 match without tick");
    rd(5'h01, 8'h02, "R3 flag untouched without tick");

    // R6 enable off: flag sets, irq stays high; enabling later lowers irq
    wr(5'h01, 8'h00);
    tick_once();
    check({7'b0, alarm_irq_n}, 8'h01, "R6 irq masked by enable");
    rd(5'h01, 8'h10, "R6 flag set while disabled");
    wr(5'h01, 8'h12);
    check({7'b0, alarm_irq_n}, 8'h00, "R6 irq after enabling");

    // full five-field match
    wr(5'h01, 8'h02);
    wr(5'h0C, 8'h07); wr(5'h0D, 8'h21); wr(5'h0E, 8'h03);
    set_cal(7'h30, 7'h15, 6'h08, 6'h21, 3'h3);
    tick_once();
    check({7'b0, alarm_irq_n}, 8'h01, "R3 hour mismatch no fire");
    set_cal(7'h30, 7'h15, 6'h07, 6'h21, 3'h4);
    tick_once();
    check({7'b0, alarm_irq_n}, 8'h01, "R3 weekday mismatch no fire");
    set_cal(7'h30, 7'h15, 6'h07, 6'h21, 3'h3);
    tick_once();
    check({7'b0, alarm_irq_n}, 8'h00, "R3 full match fires");

    // R7 match and clear in the same cycle: set wins
    wr(5'h01, 8'h02);
    check({7'b0, alarm_irq_n}, 8'h01, "R7 cleared before race");
    @(negedge clk);
    sec_tick = 1; reg_addr = 5'h01; reg_wdata = 8'h02; reg_wr = 1;
    @(negedge clk);
    sec_tick = 0; reg_wr = 0;
    check({7'b0, alarm_irq_n}, 8'h00, "R7 set beats clear");
    rd(5'h01, 8'h12, "R7 flag after race");

    // R5 all disabled again after use
    wr(5'h01, 8'h02);
    for (int i = 0; i < 5; i++) wr(5'(10 + i), 8'h80);
    tick_once();
    check({7'b0, alarm_irq_n}, 8'h01, "R5 re-disabled no fire");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule